// File: doc/BRIEF.md
# Configurable registered address buffer

This block registers the command and address bits on their way to a memory module's devices. It has two modes, chosen by static strap inputs. In the wide mode every one of 25 inputs is registered to its own output. In the split mode 14 inputs are registered, and each registered bit drives two output lanes so that twice the load can be reached. A second strap picks which 14 of the 25 inputs feed the split mode: the low group or the high group.

Outputs change only on a rising clock edge at which at least one chip-select input is asserted (low). When every chip-select input is high the outputs keep their values, which saves switching power. An asynchronous active-low reset clears the register and forces every data output low without waiting for a clock. The active-low error flag is not part of the data path and stays at its inactive high level at all times, including during reset. The straps may change only while reset is held.

Top module: `cfg_reg_buffer`

## Requirements
- R1: With cfg_split_i = 0 (wide mode), each d_i[k] for k = 0..24 is registered to q_o[k].
- R2: In wide mode, q_o[27:25] are held at 0.
- R3: With cfg_split_i = 1 and cfg_sel_b_i = 0, d_i[13:0] is registered to both q_o[13:0] and q_o[27:14].
- R4: With cfg_split_i = 1 and cfg_sel_b_i = 1, d_i[24:11] is registered to both q_o[13:0] and q_o[27:14].
- R5: In split mode, the d_i bits outside the selected 14-bit group have no effect on q_o.
- R6: A capture takes place on a rising edge of clk_i when at least one bit of cs_n_i is 0.
- R7: On a rising edge at which every bit of cs_n_i is 1, q_o keeps its previous value.
- R8: While rst_ni is 0, q_o is 0, and it becomes 0 as soon as rst_ni falls, without a clock edge.
- R9: After rst_ni rises, q_o stays 0 until the first rising clock edge, at which the first capture takes place.
- R10: err_no is 1 at all times, during reset as well as in operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_split_i | input | 1 | Strap: 0 wide mode, 1 split mode |
| cfg_sel_b_i | input | 1 | Strap: split-mode input group, 0 low group, 1 high group |
| cs_n_i | input | 2 | Active-low chip selects; any low enables a capture |
| d_i | input | 25 | Data inputs |
| q_o | output | 28 | Registered outputs |
| err_no | output | 1 | Active-low error flag, held inactive |

## Verification
The assertions check on every cycle that the unused outputs stay low in wide mode, that the two lanes agree in split mode, that a selected capture lands the right input bits one edge later, that a deselected edge leaves the outputs unchanged and that the outputs are still clear on the first edge after reset release. Only the bench's scenarios show the asynchronous side of reset, where outputs clear between clock edges, the ignored input bits in split mode, the error flag during reset and the full mapping of every input bit, swept with walking ones and arithmetic patterns over all four strap settings.

// File: rtl/cfg_buf_pkg.sv
package cfg_buf_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE    = 2'd0,
    MODE_SPLIT_A = 2'd1,
    MODE_SPLIT_B = 2'd2
  } buf_mode_e;

  function automatic buf_mode_e decode_mode(input logic split, input logic sel_b);
    if (!split)     return MODE_WIDE;
    else if (sel_b) return MODE_SPLIT_B;
    else            return MODE_SPLIT_A;
  endfunction

endpackage

// File: rtl/cfg_buf_select.sv
module cfg_buf_select
  import cfg_buf_pkg::*;
#(
  parameter int WIDE_W  = 25,
  parameter int SPLIT_W = 14
) (
  input  buf_mode_e          mode_i,
  input  logic [WIDE_W-1:0]  d_i,
  output logic [WIDE_W-1:0]  cap_o
);

  localparam int HI_LSB = WIDE_W - SPLIT_W;

  logic [SPLIT_W-1:0] grp_lo;
  logic [SPLIT_W-1:0] grp_hi;

  assign grp_lo = d_i[SPLIT_W-1:0];
  assign grp_hi = d_i[HI_LSB +: SPLIT_W];

  always_comb begin
    cap_o = '0;
    unique case (mode_i)
      MODE_SPLIT_A: cap_o[SPLIT_W-1:0] = grp_lo;
      MODE_SPLIT_B: cap_o[SPLIT_W-1:0] = grp_hi;
      default:      cap_o = d_i;
    endcase
  end

endmodule

// File: rtl/cfg_buf_core.sv
module cfg_buf_core #(
  parameter int WIDE_W = 25,
  parameter int CS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CS_W-1:0]   cs_n_i,
  input  logic [WIDE_W-1:0] cap_i,
  output logic [WIDE_W-1:0] r_o
);

  logic load;

  // any asserted select opens the register
  assign load = ~&cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   r_o <= '0;
    else if (load) r_o <= cap_i;
  end

endmodule

// File: rtl/cfg_buf_fanout.sv
module cfg_buf_fanout
  import cfg_buf_pkg::*;
#(
  parameter int WIDE_W  = 25,
  parameter int SPLIT_W = 14
) (
  input  buf_mode_e            mode_i,
  input  logic [WIDE_W-1:0]    r_i,
  output logic [2*SPLIT_W-1:0] q_o
);

  localparam int OUT_W = 2 * SPLIT_W;

  logic split;
  assign split = (mode_i != MODE_WIDE);

  for (genvar j = 0; j < OUT_W; j++) begin : g_out
    logic wide_bit;
    logic lane_bit;
    if (j < WIDE_W) begin : g_used
      assign wide_bit = r_i[j];
    end else begin : g_unused
      assign wide_bit = 1'b0;
    end
    assign lane_bit = r_i[j % SPLIT_W];
    assign q_o[j]   = split ? lane_bit : wide_bit;
  end

endmodule

// File: rtl/cfg_reg_buffer.sv
module cfg_reg_buffer
  import cfg_buf_pkg::*;
#(
  parameter int WIDE_W  = 25,
  parameter int SPLIT_W = 14,
  parameter int CS_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_split_i,
  input  logic                 cfg_sel_b_i,
  input  logic [CS_W-1:0]      cs_n_i,
  input  logic [WIDE_W-1:0]    d_i,
  output logic [2*SPLIT_W-1:0] q_o,
  output logic                 err_no
);

  buf_mode_e         mode;
  logic [WIDE_W-1:0] cap;
  logic [WIDE_W-1:0] r;

  assign mode = decode_mode(cfg_split_i, cfg_sel_b_i);

  cfg_buf_select #(.WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W)) u_sel (
    .mode_i (mode),
    .d_i    (d_i),
    .cap_o  (cap)
  );

  cfg_buf_core #(.WIDE_W(WIDE_W), .CS_W(CS_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_n_i),
    .cap_i  (cap),
    .r_o    (r)
  );

  cfg_buf_fanout #(.WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W)) u_fan (
    .mode_i (mode),
    .r_i    (r),
    .q_o    (q_o)
  );

  // parity not modelled: flag stays inactive, also in reset
  assign err_no = 1'b1;

endmodule

// File: rtl/cfg_reg_buffer_chk.sv
module cfg_reg_buffer_chk #(
  parameter int WIDE_W  = 25,
  parameter int SPLIT_W = 14,
  parameter int CS_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_split_i,
  input logic                 cfg_sel_b_i,
  input logic [CS_W-1:0]      cs_n_i,
  input logic [WIDE_W-1:0]    d_i,
  input logic [2*SPLIT_W-1:0] q_o
);

  localparam int OUT_W  = 2 * SPLIT_W;
  localparam int HI_LSB = WIDE_W - SPLIT_W;

  logic any_sel;
  assign any_sel = ~&cs_n_i;

  a_r1_wide_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_split_i && any_sel) |=> (q_o[WIDE_W-1:0] == $past(d_i)));

  a_r2_wide_unused_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_split_i |-> (q_o[OUT_W-1:WIDE_W] == '0));

  // R3 and R4: both lanes always agree in split mode
  a_r3_lanes_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_split_i |-> (q_o[SPLIT_W-1:0] == q_o[OUT_W-1:SPLIT_W]));

  a_r3_split_a_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_split_i && !cfg_sel_b_i && any_sel) |=> (q_o[SPLIT_W-1:0] == $past(d_i[SPLIT_W-1:0])));

  a_r4_split_b_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_split_i && cfg_sel_b_i && any_sel) |=> (q_o[SPLIT_W-1:0] == $past(d_i[HI_LSB +: SPLIT_W])));

  a_r7_hold_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_sel |=> $stable(q_o));

  a_r9_clear_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (q_o == '0));

endmodule

bind cfg_reg_buffer cfg_reg_buffer_chk #(
  .WIDE_W (WIDE_W),
  .SPLIT_W(SPLIT_W),
  .CS_W   (CS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_split_i (cfg_split_i),
  .cfg_sel_b_i (cfg_sel_b_i),
  .cs_n_i      (cs_n_i),
  .d_i         (d_i),
  .q_o         (q_o)
);

// File: tb/cfg_reg_buffer_test.sv
module cfg_reg_buffer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_split_i = 1'b0;
  logic        cfg_sel_b_i = 1'b0;
  logic [1:0]  cs_n_i = 2'b11;
  logic [24:0] d_i = '0;
  logic [27:0] q_o;
  logic        err_no;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [27:0] model = '0;

  cfg_reg_buffer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_split_i(cfg_split_i),
    .cfg_sel_b_i(cfg_sel_b_i), .cs_n_i(cs_n_i), .d_i(d_i),
    .q_o(q_o), .err_no(err_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [27:0] expect_q(logic split, logic selb, logic [24:0] d);
    logic [13:0] sub;
    if (!split) return {3'b000, d};
    sub = selb ? d[24:11] : d[13:0];
    return {sub, sub};
  endfunction

  task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag();
    if (!cfg_split_i) return "R1";
    return cfg_sel_b_i ? "R4" : "R3";
  endfunction

  // drive at negedge, check after the next rising edge
  task automatic step(logic [1:0] cs, logic [24:0] d, string tag);
    @(negedge clk_i);
    cs_n_i = cs;
    d_i    = d;
    @(posedge clk_i);
    if (cs != 2'b11) model = expect_q(cfg_split_i, cfg_sel_b_i, d);
    #2;
    check(tag, q_o, model);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      // straps change only under reset
      @(negedge clk_i);
      rst_ni      = 1'b0;
      cfg_split_i = cfg[1];
      cfg_sel_b_i = cfg[0];
      cs_n_i      = 2'b00;
      d_i         = '1;
      model       = '0;
      repeat (2) @(posedge clk_i);
      #2;
      check("R8 reset holds outputs low", q_o, '0);
      check("R10 error flag in reset", {27'd0, err_no}, 28'd1);

      // release between edges; first capture on next edge (R9)
      @(posedge clk_i);
      #3;
      rst_ni = 1'b1;
      #1;
      check("R9 still clear before first edge", q_o, '0);
      @(posedge clk_i);
      model = expect_q(cfg_split_i, cfg_sel_b_i, d_i);
      #2;
      check("R9 first capture after release", q_o, model);
      if (!cfg_split_i) check("R2 unused outputs low", {25'd0, q_o[27:25]}, '0);

      // walking one over all inputs, select patterns rotate (R6)
      for (int k = 0; k < 25; k++) begin
        logic [1:0] cs;
        cs = (k % 3 == 0) ? 2'b00 : ((k % 3 == 1) ? 2'b01 : 2'b10);
        step(cs, 25'd1 << k, {mode_tag(), " R6 walking one"});
      end

      // arithmetic patterns
      for (int k = 0; k < 16; k++) begin
        logic [24:0] p;
        p = 25'((k + 1) * 32'h0013_9A7D) ^ 25'(k * 32'h0155_5555);
        step(2'b10, p, {mode_tag(), " pattern"});
      end

      // R5: unselected bits toggle, selected group fixed
      if (cfg_split_i) begin
        logic [24:0] sel_mask;
        sel_mask = cfg_sel_b_i ? 25'h1FF_F800 : 25'h000_3FFF;
        step(2'b01, 25'h0AB_CDEF & sel_mask, "R5 baseline");
        for (int k = 0; k < 8; k++) begin
          logic [24:0] p;
          p = (25'h0AB_CDEF & sel_mask) | (25'(k * 32'h00A5_F0C3) & ~sel_mask);
          @(negedge clk_i);
          cs_n_i = 2'b00;
          d_i    = p;
          @(posedge clk_i);
          #2;
          check("R5 unselected inputs ignored", q_o,
                expect_q(cfg_split_i, cfg_sel_b_i, 25'h0AB_CDEF & sel_mask));
          model = q_o;
        end
      end

      // R7: all selects high, outputs hold
      step(2'b00, 25'h155_5555, {mode_tag(), " preload"});
      for (int k = 0; k < 8; k++) begin
        step(2'b11, ~25'(k * 32'h0033_3333), "R7 hold when deselected");
      end

      // R8: asynchronous clear between edges
      step(2'b00, '1, {mode_tag(), " all ones"});
      #1;
      rst_ni = 1'b0;
      #1;
      check("R8 clear without clock edge", q_o, '0);
      check("R10 error flag", {27'd0, err_no}, 28'd1);
    end
    finish_run();
  end

endmodule